// File: doc/BRIEF.md
# Multi-Modulus Feedback Frequency Divider

This block sits in the feedback path of a fractional-N frequency synthesizer. It divides a fast input clock by an integer modulus that can differ on every output period. The modulus for a period is an unsigned base integer plus a small signed correction code. The code comes from a delta-sigma modulator that runs on this divider's own output period strobe. For a 2.45 GHz output against a 26 MHz reference, the base is typically 94 and the long-run mean ratio is about 94.23.

The block takes the modulus in at each terminal count. A code that is present during the final input cycle of a period sets the length of the very next period, with no extra period of latency. Code changes at any other time leave the period in progress unchanged. The divided clock is high for the first half of each period, rounded down, and low for the rest. A one-cycle strobe marks the last input cycle of every period, and the modulator uses it as its clock.

Top module: `mmd_divider`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the counter is at the start of a period, so `div_out` is 1 and `period_stb` is 0. The first period after reset lasts `base_n` input cycles, and the correction code is ignored for that period.
- R2: Each period after the first lasts M = `base_n` + `corr` input cycles. `base_n` and `corr` are the values present in the input cycle in which `period_stb` is high at the end of the previous period.
- R3: Every code value from -3 to +3 (two's complement on `corr`) gives a period of `base_n`-3 through `base_n`+3 cycles. The code may change on every period.
- R4: Changing `base_n` or `corr` during any input cycle other than the strobe cycle has no effect on the length of the period in progress.
- R5: `period_stb` is high for exactly one input cycle per period: the last cycle of that period.
- R6: In a period of length M, `div_out` is high for the first floor(M/2) input cycles and low for the remaining cycles.
- R7: If `base_n` + `corr` is below 2, the modulus is clamped to 2. A sum of exactly 2 is used as is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low reset, synchronous to clk_in |
| base_n | input | BASE_W (8) | Unsigned base modulus |
| corr | input | CODE_W (3) | Signed correction code from the modulator |
| div_out | output | 1 | Divided clock |
| period_stb | output | 1 | One-cycle marker on the last input cycle of each period |

## Verification
The bench holds each code from -3 to +3 steady around a base of 94 and measures each period length and high time. This separates a correct signed addition from an off-by-one or a sign-handling error. A second test changes the code and the base in the middle of a period, which shows whether the modulus is taken only at the terminal count or taken continuously. Small sums below, at and just above 2 exercise the clamp. A base of 255 plus 3 exercises the widened modulus register. The first period after reset, run with a nonzero code, shows that reset loads only the base.

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int BASE_W = 8,
  parameter int CODE_W = 3
) (
  input  logic                     clk_in,
  input  logic                     rst_n,
  input  logic [BASE_W-1:0]        base_n,
  input  logic signed [CODE_W-1:0] corr,
  output logic                     div_out,
  output logic                     period_stb
);
  localparam int MW = BASE_W + 1;
  localparam int SW = BASE_W + 2;

  logic [MW-1:0]        cnt, mod_q, next_mod, base_mod;
  logic signed [SW-1:0] eff_s;

  assign eff_s    = $signed({2'b00, base_n}) + SW'(corr);
  assign next_mod = (eff_s < $signed(SW'(2))) ? MW'(2) : eff_s[MW-1:0];
  assign base_mod = (base_n < BASE_W'(2)) ? MW'(2) : {1'b0, base_n};

  assign period_stb = (cnt == mod_q - MW'(1));
  assign div_out    = (cnt < (mod_q >> 1));

  always_ff @(posedge clk_in) begin
    if (!rst_n) begin
      cnt   <= '0;
      mod_q <= base_mod;
    end else if (period_stb) begin
      cnt   <= '0;
      mod_q <= next_mod;
    end else begin
      cnt   <= cnt + MW'(1);
    end
  end
endmodule

// File: rtl/mmd_divider_chk.sv
module mmd_divider_chk #(
  parameter int MW = 9
) (
  input logic          clk_in,
  input logic          rst_n,
  input logic [MW-1:0] cnt,
  input logic [MW-1:0] mod_q,
  input logic          div_out,
  input logic          period_stb
);
  // R5
  strobe_single_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_stb |=> !period_stb);

  // R4
  mod_hold_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !period_stb |=> $stable(mod_q));

  // R7
  mod_min_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    mod_q >= MW'(2));

  // R6
  out_low_end_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_stb |-> !div_out);

  // R6
  out_high_start_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_stb |=> div_out);

  // R2
  cnt_wrap_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    period_stb |=> (cnt == '0));
endmodule

bind mmd_divider mmd_divider_chk #(.MW(MW)) u_chk (
  .clk_in(clk_in), .rst_n(rst_n), .cnt(cnt), .mod_q(mod_q),
  .div_out(div_out), .period_stb(period_stb)
);

// File: tb/sim_mmd_divider.sv
`timescale 1ns/1ps
module sim_mmd_divider;
  logic              clk_in = 1'b0;
  logic              rst_n  = 1'b0;
  logic [7:0]        base_n = 8'd10;
  logic signed [2:0] corr   = 3'sd2;
  logic              div_out, period_stb;
  int n_chk = 0, n_fail = 0, cyc = 0;

  mmd_divider u0 (.clk_in(clk_in), .rst_n(rst_n), .base_n(base_n), .corr(corr),
                  .div_out(div_out), .period_stb(period_stb));

  always #5 clk_in = ~clk_in;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk_in) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  // counts from the current negedge sample up to and including the strobe
  task automatic measure(output int len, output int hi);
    len = 0; hi = 0;
    forever begin
      len++;
      if (div_out) hi++;
      if (period_stb) break;
      @(negedge clk_in);
    end
  endtask

  task automatic sync_stb();
    do @(negedge clk_in); while (!period_stb);
  endtask

  task automatic check_mod(input int b, input int c, input int exp, input string req);
    int len, hi;
    base_n = 8'(b); corr = 3'(c);
    sync_stb();
    @(negedge clk_in);
    measure(len, hi);
    check(len == exp, req, len, exp);
    check(hi == exp / 2, "R6", hi, exp / 2);
    @(negedge clk_in);
    check(!period_stb, "R5", period_stb, 0);
  endtask

  task automatic t_reset();
    int len, hi;
    rst_n = 1'b0; base_n = 8'd10; corr = 3'sd2;
    repeat (3) @(negedge clk_in);
    check(div_out == 1'b1, "R1 div_out in reset", div_out, 1);
    check(period_stb == 1'b0, "R1 stb in reset", period_stb, 0);
    rst_n = 1'b1;
    measure(len, hi);
    check(len == 10, "R1 first period", len, 10);
    check(hi == 5, "R6 first period", hi, 5);
  endtask

  task automatic t_codes();
    for (int c = -3; c <= 3; c++) check_mod(94, c, 94 + c, "R3");
    check_mod(40, 0, 40, "R2");
    check_mod(255, 3, 258, "R2 wide");
    check_mod(17, -1, 16, "R2 odd to even");
  endtask

  task automatic t_seq();
    int len, hi;
    int codes[6] = '{3, -3, 1, -2, 0, 2};
    base_n = 8'd20; corr = 3'sd0;
    sync_stb();
    for (int i = 0; i < 6; i++) begin
      corr = 3'(codes[i]);
      sync_stb();
      @(negedge clk_in);
      measure(len, hi);
      check(len == 20 + codes[i], "R3 per-period", len, 20 + codes[i]);
    end
  endtask

  task automatic t_midchange();
    int len, hi;
    base_n = 8'd20; corr = 3'sd0;
    sync_stb();
    @(negedge clk_in);
    len = 0; hi = 0;
    forever begin
      len++;
      if (div_out) hi++;
      if (len == 3) begin corr = 3'sd3; base_n = 8'd50; end
      if (len == 8) begin base_n = 8'd21; end
      if (period_stb) break;
      @(negedge clk_in);
    end
    check(len == 20, "R4 mid-period change", len, 20);
    @(negedge clk_in);
    measure(len, hi);
    check(len == 24, "R4 takes next period", len, 24);
  endtask

  task automatic t_clamp();
    check_mod(3, -3, 2, "R7 sum 0");
    check_mod(1, -1, 2, "R7 sum 0 small base");
    check_mod(0, -3, 2, "R7 negative sum");
    check_mod(4, -2, 2, "R7 sum 2");
    check_mod(4, -1, 3, "R7 sum 3");
  endtask

  initial begin
    t_reset();
    t_codes();
    t_seq();
    t_midchange();
    t_clamp();
    finish_run();
  end
endmodule